// File: doc/BRIEF.md
# Extendable Stack Pointer Unit

This unit keeps the stack pointer of an 8051-class processor core and works out the byte address of every stack access. The core signals a push, a pop or a direct load of the pointer. The unit returns the address for the access in the same cycle, and updates the pointer at the next clock edge. A push first increments the pointer and then writes at the new value. A pop reads at the current value and then decrements.

In its default mode the pointer is eight bits wide. It wraps within the 256 bytes of internal RAM. When the extension input is high, a hardware-maintained ninth bit joins the pointer. The stack then runs through 512 locations. Pointer values with the ninth bit clear address internal RAM. Values with it set address bytes 00h to FFh of the expanded RAM. The ninth bit changes only on a carry or a borrow of the pointer, so software can read it but cannot write it. The unit also presents a control-byte view that carries the extension enable and the ninth bit, for the register file that exposes them.

Top module: `stk_ptr_top`

## Requirements
- R1: After reset the 8-bit pointer reads 07h, the ninth bit reads 0 and no stack access is signalled.
- R2: A push signals a write access at the incremented pointer in the same cycle (acc_vld_o=1, acc_wr_o=1). After the clock edge the pointer equals that incremented value.
- R3: A pop signals a read access at the current pointer in the same cycle (acc_vld_o=1, acc_wr_o=0). After the clock edge the pointer is one less.
- R4: With the extension disabled, a push from FFh goes to 00h and a pop from 00h goes to FFh. The ninth bit stays 0 and every access targets internal RAM (acc_xram_o=0).
- R5: With the extension enabled, a push from FFh with the ninth bit clear writes expanded RAM byte 00h. It leaves the pointer at 00h with the ninth bit set.
- R6: With the extension enabled and the ninth bit set, accesses target expanded RAM (acc_xram_o=1). A pop from 00h reads expanded RAM byte 00h and leaves the pointer at FFh with the ninth bit clear.
- R7: With the extension enabled, the 9-bit pointer wraps across all 512 values. A push from 1FFh writes internal byte 00h and leaves 000h. A pop from 000h reads internal byte 00h and leaves 1FFh.
- R8: A push and a pop in the same cycle, with no load, perform nothing: acc_vld_o=0 and the pointer and ninth bit hold.
- R9: A direct load replaces the 8-bit pointer and leaves the ninth bit unchanged while the extension is enabled. A load overrides a push or pop in the same cycle, and no access is signalled.
- R10: While the extension input is low, the ninth bit is forced to 0 from the next clock edge on, and the 8-bit pointer keeps its value.
- R11: The control-byte view ctl_o carries the extension enable in bit 7 and the ninth bit in bit 6. All other bits are 0.
- R12: acc_xram_o is 1 only during a valid access with the extension enabled, and only when the ninth bit of the access pointer is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| sp_wr_i | input | 1 | Direct load of the 8-bit pointer |
| sp_wdata_i | input | 8 | Value for a direct load |
| ext_en_i | input | 1 | Extended 9-bit stack mode enable |
| sp_o | output | 8 | Current 8-bit stack pointer |
| sp_hi_o | output | 1 | Read-only ninth pointer bit |
| ctl_o | output | 8 | Control-byte view: bit 7 enable, bit 6 ninth bit |
| acc_vld_o | output | 1 | A stack access takes place this cycle |
| acc_wr_o | output | 1 | 1 for a push write, 0 for a pop read |
| acc_xram_o | output | 1 | 1 selects expanded RAM, 0 internal RAM |
| acc_addr_o | output | 8 | Byte address of the stack access |

## Verification
The bench drives the pointer across each boundary where a carry or borrow can go wrong: FFh to 00h in both modes, 0FFh to 100h and back, and 1FFh to 000h. A design that let the ninth bit leak into the 8-bit mode would select expanded RAM after a plain wrap. A design that took the access address from the old pointer on a push would write one byte too low. The bench also drives simultaneous push and pop, a load that collides with a push, and dropping the enable while the ninth bit is set. Here a faulty unit would move the pointer, emit a stray access, clear the ninth bit on a load, or keep selecting expanded RAM after the mode was turned off.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned SP_AW = 8;
  localparam int unsigned SP_PW = SP_AW + 1;

  typedef logic [SP_PW-1:0] sptr_t;
  typedef logic [SP_AW-1:0] sbyte_t;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_CLASH = 3'd4
  } stk_op_e;

  // ninth bit only counts while the extension is on
  function automatic sptr_t ptr_view(input sptr_t p, input logic ext);
    sptr_t r;
    r = p;
    if (!ext) r[SP_PW-1] = 1'b0;
    return r;
  endfunction

  function automatic sptr_t ptr_up(input sptr_t p, input logic ext);
    sptr_t r;
    r = ptr_view(p, ext) + sptr_t'(1);
    if (!ext) r[SP_PW-1] = 1'b0;
    return r;
  endfunction

  function automatic sptr_t ptr_down(input sptr_t p, input logic ext);
    sptr_t r;
    r = ptr_view(p, ext) - sptr_t'(1);
    if (!ext) r[SP_PW-1] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/stk_op_decode.sv
module stk_op_decode
  import stk_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    load_i,
  output stk_op_e op_o
);
  always_comb begin
    if (load_i)                op_o = OP_LOAD;
    else if (push_i && pop_i)  op_o = OP_CLASH;
    else if (push_i)           op_o = OP_PUSH;
    else if (pop_i)            op_o = OP_POP;
    else                       op_o = OP_IDLE;
  end
endmodule

// File: rtl/stk_ptr_step.sv
module stk_ptr_step
  import stk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  stk_op_e op_i,
  input  sptr_t   cur_i,
  input  logic    ext_i,
  input  sbyte_t  wdata_i,
  output sptr_t   nxt_o,
  output sptr_t   acc_ptr_o,
  output logic    acc_vld_o,
  output logic    acc_wr_o
);
  sptr_t held;
  sptr_t up_val;
  sptr_t dn_val;

  assign held   = ptr_view(cur_i, ext_i);
  assign up_val = ptr_up(cur_i, ext_i);
  assign dn_val = ptr_down(cur_i, ext_i);

  always_comb begin
    nxt_o     = held;
    acc_ptr_o = held;
    acc_vld_o = 1'b0;
    acc_wr_o  = 1'b0;
    unique case (op_i)
      OP_PUSH: begin
        nxt_o     = up_val;
        acc_ptr_o = up_val;
        acc_vld_o = 1'b1;
        acc_wr_o  = 1'b1;
      end
      OP_POP: begin
        nxt_o     = dn_val;
        acc_vld_o = 1'b1;
      end
      OP_LOAD: nxt_o = {held[SP_PW-1], wdata_i};
      default: ;
    endcase
  end

  // R3
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_POP) |-> (acc_ptr_o[SP_AW-1:0] == cur_i[SP_AW-1:0] && !acc_wr_o));

  // R4
  narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_i |-> !nxt_o[SP_PW-1]);
endmodule

// File: rtl/stk_addr_map.sv
module stk_addr_map
  import stk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sptr_t  acc_ptr_i,
  input  logic   acc_vld_i,
  input  logic   ext_i,
  output logic   xram_o,
  output sbyte_t addr_o
);
  assign xram_o = acc_vld_i && ext_i && acc_ptr_i[SP_PW-1];
  assign addr_o = acc_ptr_i[SP_AW-1:0];

  // R12
  xram_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xram_o |-> (ext_i && acc_vld_i));
endmodule

// File: rtl/stk_ptr_top.sv
module stk_ptr_top
  import stk_pkg::*;
#(
  parameter logic [7:0] SP_RESET = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  logic       pop_i,
  input  logic       sp_wr_i,
  input  logic [7:0] sp_wdata_i,
  input  logic       ext_en_i,
  output logic [7:0] sp_o,
  output logic       sp_hi_o,
  output logic [7:0] ctl_o,
  output logic       acc_vld_o,
  output logic       acc_wr_o,
  output logic       acc_xram_o,
  output logic [7:0] acc_addr_o
);
  localparam int unsigned CTL_EN_BIT = 7;
  localparam int unsigned CTL_HI_BIT = 6;

  stk_op_e op_w;
  sptr_t   ptr_q;
  sptr_t   ptr_nxt;
  sptr_t   acc_ptr_w;
  logic    acc_vld_w;

  stk_op_decode u_dec (
    .push_i (push_i),
    .pop_i  (pop_i),
    .load_i (sp_wr_i),
    .op_o   (op_w)
  );

  stk_ptr_step u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_w),
    .cur_i     (ptr_q),
    .ext_i     (ext_en_i),
    .wdata_i   (sp_wdata_i),
    .nxt_o     (ptr_nxt),
    .acc_ptr_o (acc_ptr_w),
    .acc_vld_o (acc_vld_w),
    .acc_wr_o  (acc_wr_o)
  );

  stk_addr_map u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_ptr_i (acc_ptr_w),
    .acc_vld_i (acc_vld_w),
    .ext_i     (ext_en_i),
    .xram_o    (acc_xram_o),
    .addr_o    (acc_addr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= {1'b0, SP_RESET};
    else        ptr_q <= ptr_nxt;
  end

  assign sp_o      = ptr_q[SP_AW-1:0];
  assign sp_hi_o   = ptr_q[SP_PW-1];
  assign acc_vld_o = acc_vld_w;

  always_comb begin
    ctl_o = '0;
    ctl_o[CTL_EN_BIT] = ext_en_i;
    ctl_o[CTL_HI_BIT] = ptr_q[SP_PW-1];
  end

  // R2
  push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_PUSH) |=> (ptr_q == $past(acc_ptr_w)));

  // R8
  clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_CLASH && ext_en_i) |=> $stable(ptr_q));

  // R8
  clash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_CLASH) |-> !acc_vld_o);

  // R9
  load_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr_i && ext_en_i) |=> (sp_o == $past(sp_wdata_i) && $stable(sp_hi_o)));

  // R10
  hi_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en_i |=> !sp_hi_o);
endmodule

// File: tb/tb_stk_ptr_top.sv
module tb_stk_ptr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0, sp_wr_i = 1'b0, ext_en_i = 1'b0;
  logic [7:0] sp_wdata_i = 8'h00;
  logic [7:0] sp_o, ctl_o, acc_addr_o;
  logic       sp_hi_o, acc_vld_o, acc_wr_o, acc_xram_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic       s_vld, s_wr, s_xram;
  logic [7:0] s_addr;

  always #10 clk = ~clk;

  stk_ptr_top dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .sp_wr_i(sp_wr_i), .sp_wdata_i(sp_wdata_i), .ext_en_i(ext_en_i),
    .sp_o(sp_o), .sp_hi_o(sp_hi_o), .ctl_o(ctl_o), .acc_vld_o(acc_vld_o),
    .acc_wr_o(acc_wr_o), .acc_xram_o(acc_xram_o), .acc_addr_o(acc_addr_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply one cycle of stimulus; capture same-cycle access outputs, then pass the edge
  task automatic cyc(input logic p, input logic o, input logic w, input logic [7:0] d);
    push_i = p; pop_i = o; sp_wr_i = w; sp_wdata_i = d;
    #2;
    s_vld = acc_vld_o; s_wr = acc_wr_o; s_xram = acc_xram_o; s_addr = acc_addr_o;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0; sp_wr_i = 1'b0;
  endtask

  task automatic chk_acc(input string req, input logic v, input logic w, input logic x, input logic [7:0] a);
    chk({req, " acc_vld"}, s_vld, v);
    if (v) begin
      chk({req, " acc_wr"}, s_wr, w);
      chk({req, " acc_xram"}, s_xram, x);
      chk({req, " acc_addr"}, s_addr, a);
    end
  endtask

  task automatic chk_ptr(input string req, input logic hi, input logic [7:0] sp);
    chk({req, " sp"}, sp_o, sp);
    chk({req, " hi"}, sp_hi_o, hi);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk_ptr("R1", 1'b0, 8'h07);
    chk("R1 acc_vld", acc_vld_o, 0);
    chk("R11 ctl", ctl_o, 8'h00);
  endtask

  task automatic t_push_pop;
    cyc(1, 0, 0, 0); chk_acc("R2", 1, 1, 0, 8'h08); chk_ptr("R2", 0, 8'h08);
    cyc(1, 0, 0, 0); chk_acc("R2", 1, 1, 0, 8'h09); chk_ptr("R2", 0, 8'h09);
    cyc(0, 1, 0, 0); chk_acc("R3", 1, 0, 0, 8'h09); chk_ptr("R3", 0, 8'h08);
    cyc(0, 1, 0, 0); chk_acc("R3", 1, 0, 0, 8'h08); chk_ptr("R3", 0, 8'h07);
    cyc(0, 0, 0, 0); chk_acc("R3 idle", 0, 0, 0, 0);
  endtask

  task automatic t_narrow_wrap;
    cyc(0, 0, 1, 8'hFF); chk_ptr("R9", 0, 8'hFF);
    cyc(1, 0, 0, 0); chk_acc("R4", 1, 1, 0, 8'h00); chk_ptr("R4", 0, 8'h00);
    cyc(0, 1, 0, 0); chk_acc("R4", 1, 0, 0, 8'h00); chk_ptr("R4", 0, 8'hFF);
  endtask

  task automatic t_ext_cross;
    ext_en_i = 1'b1;
    cyc(0, 0, 0, 0); chk("R11 ctl en", ctl_o, 8'h80);
    cyc(1, 0, 0, 0); chk_acc("R5", 1, 1, 1, 8'h00); chk_ptr("R5", 1, 8'h00);
    chk("R11 ctl both", ctl_o, 8'hC0);
    cyc(1, 0, 0, 0); chk_acc("R6", 1, 1, 1, 8'h01); chk_ptr("R6", 1, 8'h01);
    cyc(0, 1, 0, 0); chk_acc("R6", 1, 0, 1, 8'h01); chk_ptr("R6", 1, 8'h00);
    cyc(0, 1, 0, 0); chk_acc("R6", 1, 0, 1, 8'h00); chk_ptr("R6", 0, 8'hFF);
    cyc(0, 1, 0, 0); chk_acc("R12", 1, 0, 0, 8'hFF); chk_ptr("R12", 0, 8'hFE);
  endtask

  task automatic t_ext_wrap;
    cyc(0, 0, 1, 8'hFF); chk_ptr("R9", 0, 8'hFF);
    cyc(1, 0, 0, 0); chk_ptr("R5", 1, 8'h00);
    cyc(0, 0, 1, 8'hFF); chk_ptr("R9 hi kept", 1, 8'hFF);
    cyc(1, 0, 0, 0); chk_acc("R7", 1, 1, 0, 8'h00); chk_ptr("R7", 0, 8'h00);
    cyc(0, 1, 0, 0); chk_acc("R7", 1, 0, 0, 8'h00); chk_ptr("R7", 1, 8'hFF);
  endtask

  task automatic t_clash;
    cyc(1, 1, 0, 0); chk_acc("R8", 0, 0, 0, 0); chk_ptr("R8", 1, 8'hFF);
    cyc(1, 0, 1, 8'h40); chk_acc("R9 override", 0, 0, 0, 0); chk_ptr("R9 override", 1, 8'h40);
    cyc(0, 1, 1, 8'h55); chk_acc("R9 override", 0, 0, 0, 0); chk_ptr("R9 override", 1, 8'h55);
  endtask

  task automatic t_ext_drop;
    ext_en_i = 1'b0;
    cyc(0, 0, 0, 0); chk_ptr("R10", 0, 8'h55); chk("R11 ctl off", ctl_o, 8'h00);
    cyc(1, 0, 0, 0); chk_acc("R10", 1, 1, 0, 8'h56); chk_ptr("R10", 0, 8'h56);
    ext_en_i = 1'b1;
    cyc(0, 0, 1, 8'hFF); cyc(1, 0, 0, 0); chk_ptr("R10 setup", 1, 8'h00);
    ext_en_i = 1'b0;
    cyc(1, 0, 0, 0); chk_acc("R12 drop", 1, 1, 0, 8'h01); chk_ptr("R10 drop", 0, 8'h01);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_narrow_wrap();
    t_ext_cross();
    t_ext_wrap();
    t_clash();
    t_ext_drop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule